// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator

This block drives four pulse-width-modulated outputs from one register bank. Each pair of channels shares an 8-bit prescaler that divides the system clock by its value plus one. A per-channel selector then divides that tick again by 1, 2, 4, 8 or 16. The result is the tick that moves the channel's counter. Each channel counts down from its period value to zero. Its output is active while the count is at or below its latched compare value, so it is high for compare+1 ticks out of period+1.

Each channel is run by a small state machine with four states. **IDLE**: never started, or finished. **RUN**: counting. **HOLD**: paused with the counter frozen. **DONE**: a one-shot period has finished. The transitions are:
- *start*: IDLE to RUN when enable is set; period and compare are loaded.
- *pause*: RUN to HOLD when enable clears.
- *resume*: HOLD to RUN when enable is set again.
- *finish*: RUN to DONE on a wrap while auto-reload is clear.
- *rearm*: DONE to IDLE when enable clears.
- *reload*: in RUN, a wrap with auto-reload set loads the period again and takes up a fresh compare value.

A channel raises a one-cycle period flag on every wrap.

Software sets the block up through a word-wide write strobe with an address. Reads are combinational.

Top module: `pwm4`

## Requirements
- R1: After reset every register reads 0, every output is 0 and no period flag is set.
- R2: The register map is as follows. Address 0x00 holds the prescale bytes: bits 7:0 for channels 0–1 and bits 15:8 for channels 2–3. Address 0x04 holds the divider selects, 4 bits per channel at bit 4·ch. Address 0x08 is the control word. Period, compare and live count are at 0x0C+12·ch, 0x10+12·ch and 0x14+12·ch. Period and compare keep only 8 bits. The live count ignores writes. Unmapped addresses read 0.
- R3: With a nonzero prescale byte P, a pair's base tick comes every P+1 clocks. An auto-reload period of value N lasts (N+1)·T clocks, where T is the channel tick interval.
- R4: A prescale byte of 0 stops both channels of that pair: no wrap occurs and their counts stay still. The other pair keeps running.
- R5: Divider select codes 0, 1, 2 and 3 divide the base tick by 2, 4, 8 and 16. Code 4, and every code above 4, divides by 1.
- R6: With inversion clear, the output is high for (min(C,N)+1)·T clocks of each period, where C is the compare value.
- R7: A compare value at or above the period value gives an output that is high for the whole period.
- R8: Control bits for channel ch sit at base b, where b is 0 for ch 0 and 4·ch+4 otherwise. Enable is bit b, inversion is bit b+2 and auto-reload is bit b+3. Setting inversion complements the output.
- R9: A compare value written during a period takes effect only from the next period.
- R10: With auto-reload clear, the channel runs one period, raises its flag once and then holds its output inactive with a count of 0. Clearing and setting enable again starts another single period.
- R11: Clearing a channel's enable forces its output to the inactive level (the inversion bit value) and freezes its count. Other channels are unaffected.
- R12: The period flag is high for exactly one clock per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| pwm_out | output | 4 | One modulated output per channel |
| period_pulse | output | 4 | One-clock flag per channel at each wrap |

## Verification
A register write lands on the clock edge that samples it. A read is valid in the same cycle, so the bench reads half a cycle after it sets the address. A new enable is acted on at the edge after the write. A new compare value waits for the next wrap. A prescale or divider change can leave one irregular period, so after any change the bench lets two wrap flags pass before it measures. It then counts clocks and high samples at falling edges from the cycle after one flag through the cycle of the next flag. That window spans exactly one period, whatever phase the prescaler has.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RUN  = 2'd1,
        CH_HOLD = 2'd2,
        CH_DONE = 2'd3
    } chan_state_t;

    localparam int EN_OFS  = 0;
    localparam int INV_OFS = 2;
    localparam int ARL_OFS = 3;

    localparam logic [7:0] A_PRE = 8'h00;
    localparam logic [7:0] A_SEL = 8'h04;
    localparam logic [7:0] A_CTL = 8'h08;

    function automatic int ctl_base(int c);
        return (c == 0) ? 0 : 4 * c + 4;
    endfunction

    function automatic logic [7:0] a_per(int c);
        return 8'(12 + 12 * c);
    endfunction

    function automatic logic [7:0] a_cmp(int c);
        return 8'(16 + 12 * c);
    endfunction

    function automatic logic [7:0] a_cnt(int c);
        return 8'(20 + 12 * c);
    endfunction
endpackage

// File: rtl/pwm4_regs.sv
module pwm4_regs
    import pwm4_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 8,
    parameter int PW  = 8,
    parameter int SW  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [7:0]                    addr,
    input  logic [31:0]                   wdata,
    output logic [31:0]                   rdata,
    input  logic [NCH-1:0][CW-1:0]        cnt_in,
    output logic [NCH/2-1:0][PW-1:0]      pre,
    output logic [NCH-1:0][SW-1:0]        sel,
    output logic [NCH-1:0]                en,
    output logic [NCH-1:0]                inv,
    output logic [NCH-1:0]                arl,
    output logic [NCH-1:0][CW-1:0]        per,
    output logic [NCH-1:0][CW-1:0]        cmp
);
    localparam int NPAIR = NCH / 2;

    logic unused_bits;
    assign unused_bits = ^wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre <= '0;
            sel <= '0;
            en  <= '0;
            inv <= '0;
            arl <= '0;
            per <= '0;
            cmp <= '0;
        end else if (we) begin
            if (addr == A_PRE) pre <= wdata[NPAIR*PW-1:0];
            if (addr == A_SEL) sel <= wdata[NCH*SW-1:0];
            for (int c = 0; c < NCH; c++) begin
                if (addr == A_CTL) begin
                    en[c]  <= wdata[ctl_base(c) + EN_OFS];
                    inv[c] <= wdata[ctl_base(c) + INV_OFS];
                    arl[c] <= wdata[ctl_base(c) + ARL_OFS];
                end
                if (addr == a_per(c)) per[c] <= wdata[CW-1:0];
                if (addr == a_cmp(c)) cmp[c] <= wdata[CW-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_PRE) rdata[NPAIR*PW-1:0] = pre;
        if (addr == A_SEL) rdata[NCH*SW-1:0] = sel;
        for (int c = 0; c < NCH; c++) begin
            if (addr == A_CTL) begin
                rdata[ctl_base(c) + EN_OFS]  = en[c];
                rdata[ctl_base(c) + INV_OFS] = inv[c];
                rdata[ctl_base(c) + ARL_OFS] = arl[c];
            end
            if (addr == a_per(c)) rdata[CW-1:0] = per[c];
            if (addr == a_cmp(c)) rdata[CW-1:0] = cmp[c];
            if (addr == a_cnt(c)) rdata[CW-1:0] = cnt_in[c];
        end
    end
endmodule

// File: rtl/pwm4_clkdiv.sv
module pwm4_clkdiv #(
    parameter int NCH = 4,
    parameter int PW  = 8,
    parameter int SW  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCH/2-1:0][PW-1:0] pre,
    input  logic [NCH-1:0][SW-1:0]   sel,
    output logic [NCH-1:0]           tick
);
    localparam int NPAIR = NCH / 2;

    logic [NPAIR-1:0] base_tick;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        logic [PW-1:0] pcnt;
        assign base_tick[p] = (pre[p] != '0) && (pcnt >= pre[p]);
        always_ff @(posedge clk) begin
            if (!rst_n || pre[p] == '0 || base_tick[p]) pcnt <= '0;
            else                                      pcnt <= pcnt + 1'b1;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_stage2
        logic [3:0] dcnt;
        logic [3:0] lim;
        always_comb begin
            if (sel[c] < SW'(4)) lim = 4'((5'd2 << sel[c][1:0]) - 5'd1);
            else                 lim = 4'd0;
        end
        assign tick[c] = base_tick[c/2] && (dcnt >= lim);
        always_ff @(posedge clk) begin
            if (!rst_n)             dcnt <= '0;
            else if (base_tick[c/2]) dcnt <= tick[c] ? 4'd0 : dcnt + 4'd1;
        end
    end
endmodule

// File: rtl/pwm4_chan.sv
module pwm4_chan
    import pwm4_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          en,
    input  logic          arl,
    input  logic          inv,
    input  logic [CW-1:0] per,
    input  logic [CW-1:0] cmp,
    output logic          pwm,
    output logic          pulse,
    output logic [CW-1:0] cnt
);
    chan_state_t st, st_nx;
    logic [CW-1:0] cmp_q;
    logic wrap;

    assign wrap = tick && (cnt == '0);

    always_comb begin
        st_nx = st;
        unique case (st)
            CH_IDLE: if (en) st_nx = CH_RUN;
            CH_RUN:  begin
                if (!en)              st_nx = CH_HOLD;
                else if (wrap && !arl) st_nx = CH_DONE;
            end
            CH_HOLD: if (en) st_nx = CH_RUN;
            CH_DONE: if (!en) st_nx = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= CH_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            cmp_q <= '0;
        end else if (st == CH_IDLE && en) begin
            cnt   <= per;
            cmp_q <= cmp;
        end else if (st == CH_RUN && en && tick) begin
            if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end else if (arl) begin
                cnt   <= per;
                cmp_q <= cmp;
            end
        end
    end

    always_comb begin
        pwm   = inv;
        pulse = 1'b0;
        unique case (st)
            CH_RUN: begin
                pwm   = (en && (cnt <= cmp_q)) ^ inv;
                pulse = en && wrap;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pwm4.sv
module pwm4
    import pwm4_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 8,
    parameter int PW  = 8,
    parameter int SW  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [7:0]     reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    output logic [NCH-1:0] pwm_out,
    output logic [NCH-1:0] period_pulse
);
    localparam int NPAIR = NCH / 2;

    logic [NPAIR-1:0][PW-1:0] pre_b;
    logic [NCH-1:0][SW-1:0]   sel_v;
    logic [NCH-1:0]           en_v, inv_v, arl_v, tick_v;
    logic [NCH-1:0][CW-1:0]   per_v, cmp_v, cnt_v;

    pwm4_regs #(.NCH(NCH), .CW(CW), .PW(PW), .SW(SW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .cnt_in(cnt_v),
        .pre(pre_b), .sel(sel_v), .en(en_v), .inv(inv_v), .arl(arl_v),
        .per(per_v), .cmp(cmp_v)
    );

    pwm4_clkdiv #(.NCH(NCH), .PW(PW), .SW(SW)) u_div (
        .clk(clk), .rst_n(rst_n), .pre(pre_b), .sel(sel_v), .tick(tick_v)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwm4_chan #(.CW(CW)) u_ch (
            .clk(clk), .rst_n(rst_n), .tick(tick_v[c]), .en(en_v[c]),
            .arl(arl_v[c]), .inv(inv_v[c]), .per(per_v[c]), .cmp(cmp_v[c]),
            .pwm(pwm_out[c]), .pulse(period_pulse[c]), .cnt(cnt_v[c])
        );
    end
endmodule

// File: rtl/pwm4_check.sv
module pwm4_check #(
    parameter int NCH = 4,
    parameter int CW  = 8,
    parameter int PW  = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NCH/2-1:0][PW-1:0] pre_b,
    input logic [NCH-1:0]           en_v,
    input logic [NCH-1:0]           inv_v,
    input logic [NCH-1:0]           arl_v,
    input logic [NCH-1:0][CW-1:0]   cnt_v,
    input logic [NCH-1:0]           pwm_out,
    input logic [NCH-1:0]           period_pulse
);
    for (genvar c = 0; c < NCH; c++) begin : g_chk
        p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !en_v[c] |=> $stable(cnt_v[c]));

        p_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (pre_b[c/2] == '0) |-> !period_pulse[c]);

        p_oneshot_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (period_pulse[c] && !arl_v[c]) |=> (pwm_out[c] == inv_v[c]));

        p_single_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
            period_pulse[c] |=> !period_pulse[c]);
    end
endmodule

bind pwm4 pwm4_check #(.NCH(NCH), .CW(CW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .pre_b(pre_b), .en_v(en_v), .inv_v(inv_v),
    .arl_v(arl_v), .cnt_v(cnt_v), .pwm_out(pwm_out), .period_pulse(period_pulse)
);

// File: tb/pwm4_test.sv
`timescale 1ns/1ps
module pwm4_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  pwm_out, period_pulse;

    always #2.5 clk = ~clk;

    pwm4 uut (
        .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .pwm_out(pwm_out),
        .period_pulse(period_pulse)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [31:0] ctl = '0;
    logic [7:0]  p0 = '0, p1 = '0;
    logic [15:0] selw = '0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    function automatic int cb(int c);
        return (c == 0) ? 0 : 4 * c + 4;
    endfunction

    function automatic int dv(int code);
        return (code < 4) ? (2 << code) : 1;
    endfunction

    task automatic set_ctl(input int c, input bit e, input bit i, input bit m);
        ctl[cb(c)] = e; ctl[cb(c)+2] = i; ctl[cb(c)+3] = m;
        wr(8'h08, ctl);
    endtask

    task automatic set_pre();
        wr(8'h00, {16'h0, p1, p0});
    endtask

    task automatic set_sel(input int c, input int code);
        selw[4*c +: 4] = 4'(code);
        wr(8'h04, {16'h0, selw});
    endtask

    task automatic wait_pulse(input int c, output bit got);
        got = 0;
        for (int k = 0; k < 5000 && !got; k++) begin
            @(negedge clk);
            if (period_pulse[c]) got = 1;
        end
    endtask

    task automatic count_period(input int c, output int hi, output int len);
        hi = 0; len = 0;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            len++;
            if (pwm_out[c]) hi++;
            if (period_pulse[c]) break;
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, c1, c2;
        bit got;
        int hi, len, t, exp_hi, bad, np;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(pwm_out == 4'h0, "R1 outputs in reset", pwm_out, 0);
        rst_n = 1'b1;
        rd(8'h00, d); check(d == 0, "R1 prescale reset", d, 0);
        rd(8'h04, d); check(d == 0, "R1 select reset", d, 0);
        rd(8'h08, d); check(d == 0, "R1 control reset", d, 0);
        rd(8'h0C, d); check(d == 0, "R1 period reset", d, 0);
        check(period_pulse == 4'h0, "R1 flags after reset", period_pulse, 0);

        // R2 / R8: register map and control bit placement (no enables set)
        wr(8'h08, 32'hFFFE_EEFE); rd(8'h08, d);
        check(d == 32'h000C_CC0C, "R8 control mask", d, 32'h000CCC0C);
        wr(8'h08, 32'h0);
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, d);
        check(d == 32'h0000_FFFF, "R2 select width", d, 32'hFFFF);
        wr(8'h04, 32'h0);
        wr(8'h00, 32'hFFFF_1234); rd(8'h00, d);
        check(d == 32'h1234, "R2 prescale width", d, 32'h1234);
        wr(8'h00, 32'h0);
        wr(8'h0C, 32'h1AB); rd(8'h0C, d);
        check(d == 32'hAB, "R2 period ch0 8-bit", d, 32'hAB);
        wr(8'h34, 32'h177); rd(8'h34, d);
        check(d == 32'h77, "R2 compare ch3 8-bit", d, 32'h77);
        wr(8'h14, 32'h55); rd(8'h14, d);
        check(d == 0, "R2 count ignores write", d, 0);
        rd(8'h80, d); check(d == 0, "R2 unmapped reads 0", d, 0);

        // R3 R5 R6 R7: sweep on channel 0
        wr(8'h0C, 32'd3);
        set_ctl(0, 1, 0, 1);
        for (int pre = 1; pre <= 2; pre++) begin
            p0 = 8'(pre); set_pre();
            for (int code = 0; code <= 4; code++) begin
                set_sel(0, code);
                for (int cm = 0; cm <= 4; cm++) begin
                    wr(8'h10, 32'(cm));
                    wait_pulse(0, got); wait_pulse(0, got); wait_pulse(0, got);
                    count_period(0, hi, len);
                    t = (pre + 1) * dv(code);
                    check(len == 4 * t, "R3 R5 period length", len, 4 * t);
                    exp_hi = ((cm < 3) ? cm + 1 : 4) * t;
                    check(hi == exp_hi, (cm >= 3) ? "R7 full duty" : "R6 duty", hi, exp_hi);
                end
            end
        end

        // R9 (and R5 code above 4): compare change waits for next period
        p0 = 8'd1; set_pre(); set_sel(0, 9);
        wr(8'h10, 32'd0);
        wait_pulse(0, got); wait_pulse(0, got); wait_pulse(0, got);
        fork
            count_period(0, hi, len);
            wr(8'h10, 32'd3);
        join
        check(len == 8, "R5 code 9 divides by 1", len, 8);
        check(hi == 2, "R9 old compare kept", hi, 2);
        count_period(0, hi, len);
        check(hi == 8, "R9 new compare next period", hi, 8);

        // R8 inversion and R12 flag on channel 2
        p1 = 8'd1; set_pre(); set_sel(2, 4);
        wr(8'h24, 32'd3); wr(8'h28, 32'd0);
        set_ctl(2, 1, 1, 1);
        wait_pulse(2, got); wait_pulse(2, got); wait_pulse(2, got);
        count_period(2, hi, len);
        check(len == 8, "R8 inverted period", len, 8);
        check(hi == 6, "R8 inverted duty", hi, 6);
        np = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (period_pulse[2]) np++;
        end
        check(np == 5, "R12 one flag per period", np, 5);

        // R11: disable freezes channel 1, channel 0 keeps going
        set_sel(1, 4); wr(8'h18, 32'd3); wr(8'h1C, 32'd3);
        set_ctl(1, 1, 0, 1);
        wait_pulse(1, got); wait_pulse(1, got);
        check(got, "R11 channel 1 running", got, 1);
        set_ctl(1, 0, 0, 1);
        rd(8'h20, c1);
        bad = 0; np = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (pwm_out[1] || period_pulse[1]) bad++;
            if (period_pulse[0]) np++;
        end
        rd(8'h20, c2);
        check(bad == 0, "R11 disabled output inactive", bad, 0);
        check(c1 == c2, "R11 count frozen", c2, c1);
        check(np == 5, "R11 other channel unaffected", np, 5);
        set_ctl(2, 0, 1, 1);
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (!pwm_out[2]) bad++;
        end
        check(bad == 0, "R11 inverted idle level high", bad, 0);

        // R4: zero prescale stops pair 1 only
        p1 = 8'd0; set_pre();
        set_ctl(2, 1, 0, 1);
        rd(8'h2C, c1);
        bad = 0; np = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (period_pulse[2]) bad++;
            if (period_pulse[0]) np++;
        end
        rd(8'h2C, c2);
        check(bad == 0, "R4 no wrap when stopped", bad, 0);
        check(c1 == c2, "R4 count still when stopped", c2, c1);
        check(np > 0, "R4 other pair runs", np, 1);

        // R10: one-shot on channel 3
        p1 = 8'd1; set_pre(); set_sel(3, 4);
        wr(8'h30, 32'd2); wr(8'h34, 32'd2);
        set_ctl(3, 1, 0, 0);
        wait_pulse(3, got);
        check(got, "R10 one-shot wrap", got, 1);
        bad = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (pwm_out[3] || period_pulse[3]) bad++;
        end
        check(bad == 0, "R10 quiet after one-shot", bad, 0);
        rd(8'h38, d);
        check(d == 0, "R10 count held at 0", d, 0);
        set_ctl(3, 0, 0, 0);
        set_ctl(3, 1, 0, 0);
        wait_pulse(3, got);
        check(got, "R10 rearm gives another period", got, 1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule